// File: doc/BRIEF.md
# Split Load Issue and Completion Tracker

This block sits between a load pipeline and a data cache that accepts at most a few requests per cycle. A load is presented with a tag, a byte address and a size. When its bytes run past the end of a cache line, the block breaks it into a low piece and a high piece. It offers the pieces on two request lanes in the same cycle, within the number of cache ports still free in that cycle. The cache answers each lane with a ready bit in the same cycle.

Every accepted load gets a tracking slot, indexed by its tag. The slot holds the number of responses still owed and a byte buffer into which the responses are merged. Writeback is raised only when the last owed response arrives. For a split load, writeback carries the merged full-width value. If the cache refuses a piece, the block raises a registered retry toward the pipeline so the load is replayed. A squash input discards a slot, and any response that arrives for it later is swallowed.

Top module: `ldt_tracker`

## Requirements
- R1: While reset is held, and in the first cycle after it, both `wb_valid` and `retry_valid` are 0. While `iss_valid` is 0, no request lane is valid and `ports_used` is 0.
- R2: A load whose line offset plus size is at most LINE_BYTES (16) is not split. It is offered only on the low lane, with its own address and size. It writes back after its one response, and the result holds response bytes 0..size-1 with every higher byte zero.
- R3: A load whose line offset plus size exceeds LINE_BYTES is split. The low lane carries the load address with size LINE_BYTES minus the offset. The high lane carries the next line-aligned address with the remaining bytes. The high lane is offered only in a cycle where the low lane is accepted.
- R4: A split load owes two responses, which may arrive in either order. The first response does not raise writeback. The second one does.
- R5: The merged result places low-piece response bytes at byte 0 upward. It places high-piece response bytes at an offset equal to the low piece's size, and it zeroes bytes at or above the load size.
- R6: If the low piece is refused, or no port is free, the high lane stays idle and no slot is taken. Retry is raised with the tag, and a later response carrying that tag produces no writeback.
- R7: If the low piece of a split load is accepted but the high piece is refused or has no port, retry is raised with the tag. The slot then owes one response, and that response completes it without writeback.
- R8: `ports_used` equals the number of request lanes valid in the cycle and never exceeds `ports_free`. The high lane needs `ports_free` of at least 2.
- R9: A squash clears the slot for its tag. A squash wins over a response to the same tag in the same cycle, and responses that arrive after the squash produce no writeback.
- R10: Writeback appears in the cycle after the final response, with that response's tag. Retry appears in the cycle after the issue it refers to. Each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A load is presented this cycle |
| iss_tag | input | TAG_W | Slot tag of the presented load |
| iss_addr | input | ADDR_W | Byte address of the load |
| iss_size | input | SIZE_W | Load size in bytes, 1..DATA_BYTES |
| ports_free | input | PORT_W | Cache ports still free this cycle |
| req_tag | output | TAG_W | Tag attached to both request lanes |
| lo_req_valid | output | 1 | Low (or only) piece offered to the cache |
| lo_req_addr | output | ADDR_W | Address of the low piece |
| lo_req_size | output | SIZE_W | Size of the low piece |
| lo_req_ready | input | 1 | Cache accepts the low piece |
| hi_req_valid | output | 1 | High piece offered to the cache |
| hi_req_addr | output | ADDR_W | Line-aligned address of the high piece |
| hi_req_size | output | SIZE_W | Size of the high piece |
| hi_req_ready | input | 1 | Cache accepts the high piece |
| ports_used | output | PORT_W | Ports consumed by this cycle's sends |
| retry_valid | output | 1 | Pipeline must replay a load |
| retry_tag | output | TAG_W | Tag of the load to replay |
| rsp_valid | input | 1 | A cache response arrives |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_half | input | 1 | 0 for the low or whole piece, 1 for the high piece |
| rsp_data | input | DATA_W | Response bytes, starting at byte 0 |
| squash_valid | input | 1 | Discard a tracked load |
| squash_tag | input | TAG_W | Tag to discard |
| wb_valid | output | 1 | A load finished and is ready to write back |
| wb_tag | output | TAG_W | Tag of the finished load |
| wb_data | output | DATA_W | Merged load result |

## Verification
The request lanes and `ports_used` are combinational in the issue cycle, so the bench reads them shortly after it drives an issue and before the next clock edge. Retry and writeback each pass through one register. The bench therefore samples them a few nanoseconds after the edge that closes the issue or response cycle. Every operation spans exactly one cycle, so each sample can belong only to the operation just driven, and the bench checks that both pulses are absent in every cycle where none is owed.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

    // Result of presenting one load to the cache in a cycle.
    typedef enum logic [1:0] {
        ISS_NONE    = 2'd0,  // nothing presented
        ISS_DROP    = 2'd1,  // low piece refused: no slot, replay
        ISS_PARTIAL = 2'd2,  // low accepted, high refused: one owed, replay
        ISS_WHOLE   = 2'd3   // every piece accepted
    } iss_result_e;

endpackage

// File: rtl/ldt_splitter.sv
module ldt_splitter #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int SIZE_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              is_split,
    output logic [SIZE_W-1:0] lo_size,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [SIZE_W-1:0] hi_size
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SUM_W = OFF_W + SIZE_W + 1;

    logic [SUM_W-1:0] offset_c;
    logic [SUM_W-1:0] end_c;
    logic [SUM_W-1:0] room_c;

    always_comb begin
        offset_c = SUM_W'(addr[OFF_W-1:0]);
        end_c    = offset_c + SUM_W'(size);
        room_c   = SUM_W'(LINE_BYTES) - offset_c;
        is_split = end_c > SUM_W'(LINE_BYTES);
        // room is below the size whenever the load is split, so it fits
        lo_size  = is_split ? SIZE_W'(room_c) : size;
        hi_size  = size - lo_size;
        hi_addr  = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + ADDR_W'(LINE_BYTES);
    end

endmodule

// File: rtl/ldt_slot.sv
module ldt_slot #(
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc,
    input  logic                    alloc_two,
    input  logic                    alloc_doom,
    input  logic [SIZE_W-1:0]       alloc_lo_size,
    input  logic [SIZE_W-1:0]       alloc_size,
    input  logic                    squash,
    input  logic                    rsp_hit,
    input  logic                    rsp_half,
    input  logic [DATA_BYTES*8-1:0] rsp_data,
    output logic                    busy,
    output logic                    retire_wb,
    output logic [DATA_BYTES*8-1:0] merged
);
    localparam int DATA_W = DATA_BYTES * 8;

    typedef struct packed {
        logic              live;
        logic              doom;
        logic [1:0]        owed;
        logic [SIZE_W-1:0] lo_size;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] bytes;
    } slot_t;

    slot_t             slot_d, slot_q;
    logic [DATA_W-1:0] hi_shift_c;

    // Lane merge: each response writes only the byte lanes it owns.
    always_comb begin
        hi_shift_c = rsp_data << {slot_q.lo_size, 3'b000};
        for (int k = 0; k < DATA_BYTES; k++) begin
            logic below_lo;
            logic below_sz;
            below_lo = SIZE_W'(k) < slot_q.lo_size;
            below_sz = SIZE_W'(k) < slot_q.size;
            if (!rsp_half && below_lo) begin
                merged[k*8 +: 8] = rsp_data[k*8 +: 8];
            end else if (rsp_half && !below_lo && below_sz) begin
                merged[k*8 +: 8] = hi_shift_c[k*8 +: 8];
            end else begin
                merged[k*8 +: 8] = slot_q.bytes[k*8 +: 8];
            end
        end
    end

    // Next state
    always_comb begin
        slot_d    = slot_q;
        retire_wb = 1'b0;
        if (rsp_hit && slot_q.live && (slot_q.owed != 2'd0)) begin
            slot_d.bytes = merged;
            slot_d.owed  = slot_q.owed - 2'd1;
            if (slot_q.owed == 2'd1) begin
                slot_d.live = 1'b0;
                retire_wb   = !slot_q.doom;
            end
        end
        if (squash) begin
            slot_d.live = 1'b0;
            slot_d.owed = 2'd0;
            retire_wb   = 1'b0;
        end
        if (alloc) begin
            slot_d.live    = 1'b1;
            slot_d.doom    = alloc_doom;
            slot_d.owed    = alloc_two ? 2'd2 : 2'd1;
            slot_d.lo_size = alloc_lo_size;
            slot_d.size    = alloc_size;
            slot_d.bytes   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy = slot_q.live;

    // A live slot always owes at least one and at most two responses
    assert_owed_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.live |-> (slot_q.owed == 2'd1 || slot_q.owed == 2'd2));

    // Squash empties the slot at the next edge
    assert_squash_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !alloc) |=> !slot_q.live);

    // A retiring slot writes back once and is then free
    assert_retire_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_wb && !alloc) |=> !slot_q.live);

    // A doomed slot never requests writeback
    assert_doom_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.live && slot_q.doom) |-> !retire_wb);

endmodule

// File: rtl/ldt_tracker.sv
module ldt_tracker #(
    parameter int ADDR_W      = 16,
    parameter int LINE_BYTES  = 16,
    parameter int DATA_BYTES  = 8,
    parameter int NUM_TAGS    = 4,
    parameter int CACHE_PORTS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             iss_valid,
    input  logic [$clog2(NUM_TAGS)-1:0]      iss_tag,
    input  logic [ADDR_W-1:0]                iss_addr,
    input  logic [$clog2(DATA_BYTES+1)-1:0]  iss_size,
    input  logic [$clog2(CACHE_PORTS+1)-1:0] ports_free,
    output logic [$clog2(NUM_TAGS)-1:0]      req_tag,
    output logic                             lo_req_valid,
    output logic [ADDR_W-1:0]                lo_req_addr,
    output logic [$clog2(DATA_BYTES+1)-1:0]  lo_req_size,
    input  logic                             lo_req_ready,
    output logic                             hi_req_valid,
    output logic [ADDR_W-1:0]                hi_req_addr,
    output logic [$clog2(DATA_BYTES+1)-1:0]  hi_req_size,
    input  logic                             hi_req_ready,
    output logic [$clog2(CACHE_PORTS+1)-1:0] ports_used,
    output logic                             retry_valid,
    output logic [$clog2(NUM_TAGS)-1:0]      retry_tag,
    input  logic                             rsp_valid,
    input  logic [$clog2(NUM_TAGS)-1:0]      rsp_tag,
    input  logic                             rsp_half,
    input  logic [DATA_BYTES*8-1:0]          rsp_data,
    input  logic                             squash_valid,
    input  logic [$clog2(NUM_TAGS)-1:0]      squash_tag,
    output logic                             wb_valid,
    output logic [$clog2(NUM_TAGS)-1:0]      wb_tag,
    output logic [DATA_BYTES*8-1:0]          wb_data
);
    import ldt_pkg::*;

    localparam int TAG_W  = $clog2(NUM_TAGS);
    localparam int SIZE_W = $clog2(DATA_BYTES + 1);
    localparam int PORT_W = $clog2(CACHE_PORTS + 1);
    localparam int DATA_W = DATA_BYTES * 8;

    typedef struct packed {
        logic              wb_valid;
        logic [TAG_W-1:0]  wb_tag;
        logic [DATA_W-1:0] wb_data;
        logic              retry_valid;
        logic [TAG_W-1:0]  retry_tag;
    } trk_t;

    trk_t              trk_d, trk_q;
    iss_result_e       result_c;
    logic              split_c;
    logic [SIZE_W-1:0] lo_size_c;
    logic [SIZE_W-1:0] hi_size_c;
    logic [ADDR_W-1:0] hi_addr_c;
    logic              lo_ok_c;
    logic              hi_ok_c;
    logic              alloc_c;

    logic [NUM_TAGS-1:0] busy_vec;
    logic [NUM_TAGS-1:0] retire_vec;
    logic [DATA_W-1:0]   merged_arr [NUM_TAGS];

    ldt_splitter #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .SIZE_W    (SIZE_W)
    ) u_split (
        .addr    (iss_addr),
        .size    (iss_size),
        .is_split(split_c),
        .lo_size (lo_size_c),
        .hi_addr (hi_addr_c),
        .hi_size (hi_size_c)
    );

    // Issue path: the high piece goes out only beside an accepted low piece
    always_comb begin
        req_tag      = iss_tag;
        lo_req_valid = iss_valid && (int'(ports_free) >= 1);
        lo_req_addr  = iss_addr;
        lo_req_size  = lo_size_c;
        lo_ok_c      = lo_req_valid && lo_req_ready;
        hi_req_valid = iss_valid && split_c && lo_ok_c && (int'(ports_free) >= 2);
        hi_req_addr  = hi_addr_c;
        hi_req_size  = hi_size_c;
        hi_ok_c      = hi_req_valid && hi_req_ready;
        ports_used   = PORT_W'(lo_req_valid) + PORT_W'(hi_req_valid);

        if (!iss_valid) begin
            result_c = ISS_NONE;
        end else if (!lo_ok_c) begin
            result_c = ISS_DROP;
        end else if (split_c && !hi_ok_c) begin
            result_c = ISS_PARTIAL;
        end else begin
            result_c = ISS_WHOLE;
        end
        alloc_c = (result_c == ISS_PARTIAL) || (result_c == ISS_WHOLE);
    end

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
        ldt_slot #(
            .DATA_BYTES(DATA_BYTES),
            .SIZE_W    (SIZE_W)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc        (alloc_c && (iss_tag == TAG_W'(i))),
            .alloc_two    (result_c == ISS_WHOLE && split_c),
            .alloc_doom   (result_c == ISS_PARTIAL),
            .alloc_lo_size(lo_size_c),
            .alloc_size   (iss_size),
            .squash       (squash_valid && (squash_tag == TAG_W'(i))),
            .rsp_hit      (rsp_valid && (rsp_tag == TAG_W'(i))),
            .rsp_half     (rsp_half),
            .rsp_data     (rsp_data),
            .busy         (busy_vec[i]),
            .retire_wb    (retire_vec[i]),
            .merged       (merged_arr[i])
        );
    end

    // Writeback and retry pulses
    always_comb begin
        trk_d             = '0;
        trk_d.wb_valid    = rsp_valid && retire_vec[rsp_tag];
        trk_d.wb_tag      = rsp_tag;
        trk_d.wb_data     = trk_d.wb_valid ? merged_arr[rsp_tag] : '0;
        trk_d.retry_valid = (result_c == ISS_DROP) || (result_c == ISS_PARTIAL);
        trk_d.retry_tag   = iss_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign wb_valid    = trk_q.wb_valid;
    assign wb_tag      = trk_q.wb_tag;
    assign wb_data     = trk_q.wb_data;
    assign retry_valid = trk_q.retry_valid;
    assign retry_tag   = trk_q.retry_tag;

    assert_port_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ports_used <= ports_free);

    assert_hi_beside_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_req_valid |-> (lo_req_valid && lo_req_ready));

    assert_wb_follows_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(rsp_valid) && $past(rsp_tag) == wb_tag));

    assert_retry_follows_iss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> ($past(iss_valid) && $past(iss_tag) == retry_tag));

    assert_retry_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !lo_req_ready) |=> !busy_vec[$past(iss_tag)]);

endmodule

// File: tb/sim_ldt_tracker.sv
module sim_ldt_tracker;

    localparam int NT = 4;
    localparam int LB = 16;
    localparam int DB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_tag = '0;
    logic [15:0] iss_addr = '0;
    logic [3:0]  iss_size = '0;
    logic [1:0]  ports_free = '0;
    logic [1:0]  req_tag;
    logic        lo_req_valid;
    logic [15:0] lo_req_addr;
    logic [3:0]  lo_req_size;
    logic        lo_req_ready = 1'b0;
    logic        hi_req_valid;
    logic [15:0] hi_req_addr;
    logic [3:0]  hi_req_size;
    logic        hi_req_ready = 1'b0;
    logic [1:0]  ports_used;
    logic        retry_valid;
    logic [1:0]  retry_tag;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_tag = '0;
    logic        rsp_half = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        squash_valid = 1'b0;
    logic [1:0]  squash_tag = '0;
    logic        wb_valid;
    logic [1:0]  wb_tag;
    logic [63:0] wb_data;

    int total = 0;
    int bad = 0;

    // model per tag
    bit          pend_lo [NT];
    bit          pend_hi [NT];
    bit          wants   [NT];
    int          m_lo    [NT];
    int          m_sz    [NT];
    logic [63:0] d_lo    [NT];
    logic [63:0] d_hi    [NT];

    // expectations for the registered outputs of the current cycle
    bit          e_retry;
    logic [1:0]  e_retry_tag;
    bit          e_wb;
    logic [1:0]  e_wb_tag;
    logic [63:0] e_wb_data;

    always #10 clk = ~clk;

    ldt_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_size(iss_size),
        .ports_free(ports_free), .req_tag(req_tag),
        .lo_req_valid(lo_req_valid), .lo_req_addr(lo_req_addr), .lo_req_size(lo_req_size),
        .lo_req_ready(lo_req_ready),
        .hi_req_valid(hi_req_valid), .hi_req_addr(hi_req_addr), .hi_req_size(hi_req_size),
        .hi_req_ready(hi_req_ready), .ports_used(ports_used),
        .retry_valid(retry_valid), .retry_tag(retry_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_half(rsp_half), .rsp_data(rsp_data),
        .squash_valid(squash_valid), .squash_tag(squash_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] merge_exp(int los, int sz, logic [63:0] lo, logic [63:0] hi);
        logic [63:0] r = '0;
        for (int k = 0; k < DB; k++) begin
            if (k < los) r[k*8 +: 8] = lo[k*8 +: 8];
            else if (k < sz) r[k*8 +: 8] = hi[(k-los)*8 +: 8];
        end
        return r;
    endfunction

    task automatic clear_inputs();
        iss_valid = 1'b0; lo_req_ready = 1'b0; hi_req_ready = 1'b0; ports_free = '0;
        rsp_valid = 1'b0; squash_valid = 1'b0;
    endtask

    // wait for the closing edge, then sample the registered pulses
    task automatic close_cycle(string rq);
        @(posedge clk);
        #3;
        check({rq, " retry_valid (R10)"}, 64'(retry_valid), 64'(e_retry));
        if (e_retry) check({rq, " retry_tag"}, 64'(retry_tag), 64'(e_retry_tag));
        check({rq, " wb_valid (R10)"}, 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            check({rq, " wb_tag"}, 64'(wb_tag), 64'(e_wb_tag));
            check("R5 wb_data merge", wb_data, e_wb_data);
        end
        clear_inputs();
    endtask

    task automatic do_issue(int tag, logic [15:0] addr, int size, int pfree, bit lrdy, bit hrdy);
        int  off, los, his;
        bit  spl, elo, ehi, lo_ok, hi_ok;
        logic [15:0] hia;
        @(negedge clk);
        iss_valid = 1'b1; iss_tag = 2'(tag); iss_addr = addr; iss_size = 4'(size);
        ports_free = 2'(pfree); lo_req_ready = lrdy; hi_req_ready = hrdy;
        off = int'(addr) % LB;
        spl = (off + size) > LB;
        los = spl ? LB - off : size;
        his = size - los;
        hia = addr - 16'(off) + 16'(LB);
        elo = pfree >= 1;
        ehi = spl && elo && lrdy && pfree >= 2;
        #2;
        check("R8 lo_req_valid", 64'(lo_req_valid), 64'(elo));
        if (elo) begin
            check("R3 lo_req_addr", 64'(lo_req_addr), 64'(addr));
            check(spl ? "R3 lo_req_size" : "R2 lo_req_size", 64'(lo_req_size), 64'(los));
            check("R2 req_tag", 64'(req_tag), 64'(tag));
        end
        check(spl ? "R3 hi_req_valid" : "R2 hi_req_valid", 64'(hi_req_valid), 64'(ehi));
        if (ehi) begin
            check("R3 hi_req_addr", 64'(hi_req_addr), 64'(hia));
            check("R3 hi_req_size", 64'(hi_req_size), 64'(his));
        end
        check("R8 ports_used", 64'(ports_used), 64'(int'(elo) + int'(ehi)));
        lo_ok = elo && lrdy;
        hi_ok = ehi && hrdy;
        e_wb = 1'b0;
        e_retry_tag = 2'(tag);
        if (!lo_ok) begin
            e_retry = 1'b1;                       // R6
        end else if (spl && !hi_ok) begin
            e_retry = 1'b1;                       // R7
            pend_lo[tag] = 1'b1; pend_hi[tag] = 1'b0; wants[tag] = 1'b0;
        end else begin
            e_retry = 1'b0;
            pend_lo[tag] = 1'b1; pend_hi[tag] = spl; wants[tag] = 1'b1;
        end
        m_lo[tag] = los; m_sz[tag] = size;
        close_cycle(lo_ok ? (spl && !hi_ok ? "R7" : "R2") : "R6");
    endtask

    task automatic do_rsp(int tag, bit half, logic [63:0] data);
        bit hit = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = 2'(tag); rsp_half = half; rsp_data = data;
        if (!half && pend_lo[tag]) begin
            pend_lo[tag] = 1'b0; d_lo[tag] = data; hit = 1'b1;
        end else if (half && pend_hi[tag]) begin
            pend_hi[tag] = 1'b0; d_hi[tag] = data; hit = 1'b1;
        end
        e_retry = 1'b0;
        e_wb = hit && !pend_lo[tag] && !pend_hi[tag] && wants[tag];
        e_wb_tag = 2'(tag);
        e_wb_data = merge_exp(m_lo[tag], m_sz[tag], d_lo[tag], d_hi[tag]);
        if (e_wb) wants[tag] = 1'b0;
        close_cycle(hit ? "R4" : "R6");
    endtask

    task automatic do_squash(int tag);
        @(negedge clk);
        squash_valid = 1'b1; squash_tag = 2'(tag);
        wants[tag] = 1'b0;
        e_retry = 1'b0; e_wb = 1'b0;
        close_cycle("R9");
    endtask

    task automatic do_idle();
        @(negedge clk);
        e_retry = 1'b0; e_wb = 1'b0;
        #2;
        check("R1 lo_req_valid idle", 64'(lo_req_valid), 64'd0);
        check("R1 ports_used idle", 64'(ports_used), 64'd0);
        close_cycle("R1");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20240611));
        for (int t = 0; t < NT; t++) begin
            pend_lo[t] = 0; pend_hi[t] = 0; wants[t] = 0; m_lo[t] = 0; m_sz[t] = 0;
            d_lo[t] = '0; d_hi[t] = '0;
        end
        repeat (3) @(posedge clk);
        #3;
        check("R1 wb_valid in reset", 64'(wb_valid), 64'd0);
        check("R1 retry_valid in reset", 64'(retry_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        e_retry = 1'b0; e_wb = 1'b0;
        close_cycle("R1");

        // R2: unsplit, then response
        do_issue(0, 16'h0100, 4, 2, 1, 1);
        do_rsp(0, 0, 64'hA1A2A3A4_B1B2B3B4);
        // R3 boundary: offset 8 + size 8 ends on the line, not split
        do_issue(1, 16'h0108, 8, 2, 1, 1);
        do_rsp(1, 0, 64'h1122334455667788);
        // R4/R5: split, high response first
        do_issue(1, 16'h020C, 8, 2, 1, 1);
        do_rsp(1, 1, 64'hFFFFFFFF_C4C3C2C1);
        do_rsp(1, 0, 64'hEEEEEEEE_D4D3D2D1);
        // R6: low refused, then stray response
        do_issue(2, 16'h0300, 2, 2, 0, 1);
        do_rsp(2, 0, 64'h5555);
        // R6: no free port
        do_issue(2, 16'h030F, 4, 0, 1, 1);
        // R7: split with only one port, then the owed response
        do_issue(2, 16'h04FE, 6, 1, 1, 1);
        do_rsp(2, 0, 64'h77);
        // R7: split with high refused
        do_issue(3, 16'h05F9, 8, 2, 1, 0);
        do_rsp(3, 0, 64'h99);
        // R9: squash then late response
        do_issue(3, 16'h0600, 8, 2, 1, 1);
        do_squash(3);
        do_rsp(3, 0, 64'h1234);
        do_idle();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 4) begin
                int start, tag;
                start = int'($urandom % NT);
                tag = -1;
                for (int j = 0; j < NT; j++) begin
                    int c;
                    c = (start + j) % NT;
                    if (tag < 0 && !pend_lo[c] && !pend_hi[c]) tag = c;
                end
                if (tag >= 0) begin
                    int pf, q;
                    q = int'($urandom % 8);
                    pf = (q == 0) ? 0 : (q == 1) ? 1 : 2;
                    do_issue(tag, 16'($urandom), 1 + int'($urandom % DB), pf,
                             ($urandom % 8) != 0, ($urandom % 8) != 0);
                end else begin
                    do_idle();
                end
            end else if (r < 9) begin
                int start, tag;
                start = int'($urandom % NT);
                tag = -1;
                for (int j = 0; j < NT; j++) begin
                    int c;
                    c = (start + j) % NT;
                    if (tag < 0 && (pend_lo[c] || pend_hi[c])) tag = c;
                end
                if (tag >= 0) begin
                    bit h;
                    if (pend_lo[tag] && pend_hi[tag]) h = 1'($urandom % 2);
                    else h = pend_hi[tag];
                    if (r == 8 && wants[tag]) do_squash(tag);
                    else do_rsp(tag, h, {$urandom, $urandom});
                end else begin
                    do_idle();
                end
            end else begin
                do_idle();
            end
        end

        // drain everything still owed
        for (int t = 0; t < NT; t++) begin
            if (pend_lo[t]) do_rsp(t, 0, {$urandom, $urandom});
            if (pend_hi[t]) do_rsp(t, 1, {$urandom, $urandom});
        end
        do_idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule